// File: doc/BRIEF.md
# Coherent Clock Register Read Port

This block is the byte-level read side of a bank of timekeeping registers. It sits behind a serial-bus slave that has already decoded start, address and stop events. When a read opens, the block freezes a copy of every live clock register in the same clock edge. Each byte it then hands out comes from that frozen copy. A seconds tick in the middle of a multi-byte transfer therefore cannot give a torn time value, such as minutes taken after a rollover paired with seconds taken before it.

An internal pointer selects the register that the next byte comes from. The pointer can be loaded for a random read. It advances by one after each byte, and it wraps inside the register bank so that it never runs into any other storage. The pointer keeps its value across a stop. A later read that skips the address load continues at the register after the last one returned.

Top module: `ccr_read_port`

## Requirements
- R1: After reset, `rd_valid_o` is 0, `rd_data_o` is 0, no read is open and the pointer is 0.
- R2: A `rd_start_i` pulse copies all `NUM_REGS` live registers into the holding buffer on that same clock edge and opens a read. Register k is `live_i[k*DATA_W +: DATA_W]`. Every byte of that read comes from the buffer, whatever `live_i` does afterwards.
- R3: `addr_load_i` sets the pointer to `addr_i` when `addr_i < NUM_REGS`, and to 0 otherwise. When a load and a byte request arrive in the same cycle, the byte uses the old pointer and the load decides the next pointer.
- R4: A `byte_req_i` pulse while a read is open makes `rd_valid_o` 1 in the next cycle, with `rd_data_o` equal to the buffered register at the pointer. The pointer then increments.
- R5: Advancing from address `NUM_REGS-1` sets the pointer to 0.
- R6: `stop_i` closes the read. While no read is open, `byte_req_i` is ignored: `rd_valid_o` stays 0, `rd_data_o` holds its value and the pointer does not move.
- R7: After a stop, the pointer equals the last address read plus 1, wrapped. A new read opened without a load returns that register first.
- R8: `rd_valid_o` is high for exactly one cycle per accepted byte request and is never high otherwise.
- R9: A `rd_start_i` pulse while a read is already open takes a fresh snapshot. Later bytes show the new live values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start_i | input | 1 | Opens a read and captures the snapshot |
| addr_load_i | input | 1 | Loads the register pointer |
| addr_i | input | ADDR_W | Address to load |
| byte_req_i | input | 1 | Requests the next byte |
| stop_i | input | 1 | Closes the open read |
| live_i | input | NUM_REGS*DATA_W | Live clock registers, register k at bits k*DATA_W |
| rd_data_o | output | DATA_W | Byte returned |
| rd_valid_o | output | 1 | One-cycle strobe marking `rd_data_o` as new |

## Verification
The bench uses a six-register bank. It sweeps every loadable start address, including the two codes beyond the bank, against read lengths from one to eight bytes. The live values change at random between reads, so an out-of-range load, a missing wrap or a stale buffer all produce a wrong byte. A dedicated pattern rolls the seconds, minutes and hours over in the middle of a read. Only a snapshot held for the whole transfer returns the pre-rollover time there; a design that reads the live registers directly fails. Further patterns issue byte requests after a stop, continue at the current address without a load, overlap a load with a request, and restart an open read. These separate a pointer that holds correctly from one that drifts, and a buffer that refreshes on a restart from one that does not.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef struct packed {
        logic open;
        logic valid;
    } ccr_ctrl_t;

endpackage

// File: rtl/ccr_ptr.sv
module ccr_ptr #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic              addr_ok;

    assign addr_ok = (int'(addr_i) < NUM_REGS);

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = addr_ok ? addr_i : '0;
        end else if (adv_i) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R5: advancing past the top of the bank lands on address 0
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && ptr_q == LAST) |=> (ptr_q == '0));

    // R6: the pointer moves only on a load or an accepted byte
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(ptr_q));

    // R3: the pointer never leaves the bank
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r3_ptr_in_bank: assert (int'(ptr_q) < NUM_REGS);
        end
    end

endmodule

// File: rtl/ccr_snap.sv
module ccr_snap #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture_i,
    input  logic [NUM_REGS*DATA_W-1:0]   live_i,
    input  logic [ADDR_W-1:0]            sel_i,
    output logic [DATA_W-1:0]            byte_o
);

    localparam int BANK_W = NUM_REGS * DATA_W;

    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = capture_i ? live_i : bank_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign byte_o = bank_q[int'(sel_i)*DATA_W +: DATA_W];

    // R2: the buffer takes the live values on the capture edge
    a_r2_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (bank_q == $past(live_i)));

    // R2: without a capture the buffer is frozen
    a_r2_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(bank_q));

endmodule

// File: rtl/ccr_read_port.sv
module ccr_read_port
    import ccr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_start_i,
    input  logic                       addr_load_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       byte_req_i,
    input  logic                       stop_i,
    input  logic [NUM_REGS*DATA_W-1:0] live_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic                       rd_valid_o
);

    ccr_ctrl_t         ctrl_d, ctrl_q;
    logic [DATA_W-1:0] data_d, data_q;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] snap_byte;
    logic              accept;

    assign accept = byte_req_i && ctrl_q.open;

    ccr_ptr #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) ptr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_load_i),
        .addr_i (addr_i),
        .adv_i  (accept),
        .ptr_o  (ptr)
    );

    ccr_snap #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) snap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (rd_start_i),
        .live_i    (live_i),
        .sel_i     (ptr),
        .byte_o    (snap_byte)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        data_d = data_q;
        if (rd_start_i)  ctrl_d.open = 1'b1;
        else if (stop_i) ctrl_d.open = 1'b0;
        ctrl_d.valid = accept;
        if (accept) data_d = snap_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            data_q <= data_d;
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = ctrl_q.valid;

    // R4: an accepted request yields a strobe next cycle
    a_r4_req_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req_i && ctrl_q.open) |=> rd_valid_o);

    // R8: no strobe without an accepted request
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_req_i && ctrl_q.open) |=> !rd_valid_o);

    // R6: the output byte holds between accepted requests
    a_r6_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_req_i && ctrl_q.open) |=> $stable(rd_data_o));

endmodule

// File: tb/ccr_read_port_tb_top.sv
module ccr_read_port_tb_top;

    localparam int NR = 6;
    localparam int DW = 8;
    localparam int AW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rd_start_i = 1'b0;
    logic           addr_load_i = 1'b0;
    logic [AW-1:0]  addr_i = '0;
    logic           byte_req_i = 1'b0;
    logic           stop_i = 1'b0;
    logic [DW-1:0]  live [NR];
    logic [NR*DW-1:0] live_i;
    logic [DW-1:0]  rd_data_o;
    logic           rd_valid_o;

    int n_run = 0;
    int n_fail = 0;
    logic [DW-1:0] snap [NR];
    int exp_ptr = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NR; k++) live_i[k*DW +: DW] = live[k];
    end

    ccr_read_port #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_start_i  (rd_start_i),
        .addr_load_i (addr_load_i),
        .addr_i      (addr_i),
        .byte_req_i  (byte_req_i),
        .stop_i      (stop_i),
        .live_i      (live_i),
        .rd_data_o   (rd_data_o),
        .rd_valid_o  (rd_valid_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        rd_start_i = 1'b1;
        for (int k = 0; k < NR; k++) snap[k] = live[k];
        @(negedge clk);
        rd_start_i = 1'b0;
    endtask

    task automatic do_load(input int a);
        @(negedge clk);
        addr_load_i = 1'b1;
        addr_i = AW'(a);
        exp_ptr = (a < NR) ? a : 0;
        @(negedge clk);
        addr_load_i = 1'b0;
    endtask

    task automatic do_byte(input string req);
        @(negedge clk);
        byte_req_i = 1'b1;
        @(negedge clk);
        byte_req_i = 1'b0;
        check(req, {31'd0, rd_valid_o}, 32'd1);
        check(req, {24'd0, rd_data_o}, {24'd0, snap[exp_ptr]});
        exp_ptr = (exp_ptr + 1) % NR;
        @(negedge clk);
        check("R8", {31'd0, rd_valid_o}, 32'd0);
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic randomize_live();
        for (int k = 0; k < NR; k++) live[k] = DW'($urandom);
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NR; k++) live[k] = DW'(8'h10 + k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, rd_valid_o}, 32'd0);
        check("R1", {24'd0, rd_data_o}, 32'd0);
        // R1: pointer starts at 0
        do_start();
        exp_ptr = 0;
        do_byte("R1");
        do_stop();

        // R2: seconds rollover in the middle of a read
        live[0] = 8'h59; live[1] = 8'h59; live[2] = 8'h23;
        live[3] = 8'h31; live[4] = 8'h12; live[5] = 8'h99;
        do_start();
        do_load(0);
        do_byte("R2");
        live[0] = 8'h00; live[1] = 8'h00; live[2] = 8'h00;
        live[3] = 8'h01; live[4] = 8'h01; live[5] = 8'h00;
        for (int b = 1; b < NR; b++) do_byte("R2");
        do_stop();
        // R2: a new read sees the updated time
        do_start();
        do_load(0);
        check("R2", {24'd0, snap[0]}, 32'h00);
        do_byte("R2");
        do_stop();

        // R3, R4, R5: sweep start addresses (incl. out of range) and lengths
        for (int a = 0; a < 8; a++) begin
            for (int len = 1; len <= 8; len++) begin
                randomize_live();
                do_start();
                do_load(a);
                randomize_live();
                for (int b = 0; b < len; b++) do_byte((a >= NR) ? "R3" : "R5");
                do_stop();
            end
        end

        // R6: requests after stop are ignored
        randomize_live();
        do_start();
        do_load(2);
        do_byte("R4");
        do_stop();
        begin
            logic [DW-1:0] held;
            held = rd_data_o;
            for (int r = 0; r < 3; r++) begin
                @(negedge clk);
                byte_req_i = 1'b1;
                @(negedge clk);
                byte_req_i = 1'b0;
                check("R6", {31'd0, rd_valid_o}, 32'd0);
                check("R6", {24'd0, rd_data_o}, {24'd0, held});
            end
        end
        // R7: current-address read continues at last + 1 (address 3)
        randomize_live();
        do_start();
        check("R7", exp_ptr, 3);
        do_byte("R7");
        do_byte("R7");
        do_stop();

        // R3: load and request in the same cycle
        randomize_live();
        do_start();
        do_load(1);
        @(negedge clk);
        byte_req_i = 1'b1; addr_load_i = 1'b1; addr_i = AW'(4);
        @(negedge clk);
        byte_req_i = 1'b0; addr_load_i = 1'b0;
        check("R3", {24'd0, rd_data_o}, {24'd0, snap[1]});
        exp_ptr = 4;
        do_byte("R3");
        do_stop();

        // R9: restart while open refreshes the snapshot
        randomize_live();
        do_start();
        do_load(5);
        randomize_live();
        do_start();
        do_byte("R9");
        do_byte("R9");
        do_stop();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule